// File: doc/BRIEF.md
# Slow-Mode Clock Ratio Divider

This block runs on the crystal or external reference clock while the system is in its low-power slow mode. It produces three clock-enable pulse streams: one for the core clock (F), one for the bus clock (H) and one for the peripheral clock (P). It also drives a divided square wave that can be observed. Downstream logic uses the enables to advance on the reference clock at the slower rates, so no second clock tree is needed.

The base ratio comes from a small slow-value code. Code 0 passes the reference rate straight through. Any nonzero code n divides by 2n. A bus-halving select doubles the H period relative to F. A peripheral-halving select doubles the P period relative to H. All pulses stay on a common grid. The block takes in a new code or select value only at the end of the longest running period, which is the cycle that carries a P pulse. This means no stream ever sees a shortened period.

Top module: `slow_clk_ratio_div`

## Requirements
- R1: While `rst` is high, `fclk_en`, `hclk_en`, `pclk_en` and `div_clk_obs` are all low on the following cycle.
- R2: With an active code of 0, `fclk_en` is high on every reference cycle.
- R3: With an active nonzero code n, `fclk_en` pulses for one cycle every 2n reference cycles.
- R4: With `hclk_half` = 0, `hclk_en` pulses on every `fclk_en` pulse. With `hclk_half` = 1, it pulses on every second one, so its period is twice the F period.
- R5: With `pclk_half` = 0, `pclk_en` pulses on every `hclk_en` pulse. With `pclk_half` = 1, it pulses on every second one.
- R6: `hclk_en` is never high without `fclk_en`, and `pclk_en` is never high without `hclk_en`.
- R7: A new code or select value has no effect until the next `pclk_en` pulse. Up to and including that pulse, all streams keep the old spacing. From that pulse on, the new periods count from it as cycle 0.
- R8: For an even ratio R, `div_clk_obs` is high during the first R/2 cycles of each F period and low during the rest. Cycle 0 of a period is the cycle that carries the `fclk_en` pulse. For ratio 1, `div_clk_obs` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_code | input | CODE_W | Slow-value ratio code (0: divide by 1, n: divide by 2n) |
| hclk_half | input | 1 | Doubles the H period relative to F when 1 |
| pclk_half | input | 1 | Doubles the P period relative to H when 1 |
| fclk_en | output | 1 | Core-clock enable pulse |
| hclk_en | output | 1 | Bus-clock enable pulse |
| pclk_en | output | 1 | Peripheral-clock enable pulse |
| div_clk_obs | output | 1 | Divided core clock for observation |

## Verification
The bench sweeps every code with every select combination. For each one it predicts the exact cycle of every pulse and every level of the observed clock from modular arithmetic on the ratio. This catches a linear ratio map, where code n would divide by n instead of 2n. It also catches halving stages that do not restart on the common boundary, which would leave H or P pulses off the F grid. A separate case switches from the longest setting to divide-by-1 in the middle of a period. A design that took the change at once would produce extra F pulses before the P boundary. The square-wave check exposes a duty counter that measures from the wrong phase or that mishandles ratio 1.

// File: rtl/slowdiv_pkg.sv
package slowdiv_pkg;
  parameter int SD_CODE_W = 3;

  typedef struct packed {
    logic [SD_CODE_W-1:0] code;
    logic                 h_half;
    logic                 p_half;
  } slowdiv_cfg_t;
endpackage

// File: rtl/slowdiv_cfg_hold.sv
module slowdiv_cfg_hold
  import slowdiv_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         boundary,
  input  slowdiv_cfg_t cfg_in,
  output slowdiv_cfg_t cfg_act,
  output slowdiv_cfg_t cfg_nxt
);
  // The requested settings are taken in only when the longest period ends.
  always_comb cfg_nxt = boundary ? cfg_in : cfg_act;

  always_ff @(posedge clk) begin
    if (rst) cfg_act <= '0;
    else     cfg_act <= cfg_nxt;
  end
endmodule

// File: rtl/slowdiv_base_counter.sv
module slowdiv_base_counter #(
  parameter int CODE_W = 3,
  localparam int CNT_W = $clog2(2 * (1 << CODE_W))
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code_act,
  input  logic [CODE_W-1:0] code_nxt,
  output logic              f_wrap,
  output logic              obs_nxt
);
  logic [CNT_W-1:0] fcnt;
  logic [CNT_W-1:0] flim;
  logic [CNT_W-1:0] fcnt_n;
  logic [CNT_W-1:0] half_n;

  // Code 0 means divide by 1. Code n means divide by 2n, so the last index is 2n-1.
  always_comb begin
    if (code_act == '0) flim = '0;
    else                flim = CNT_W'({code_act, 1'b0}) - CNT_W'(1);
    f_wrap = (fcnt == flim);
    fcnt_n = f_wrap ? '0 : fcnt + CNT_W'(1);
    half_n = CNT_W'(code_nxt);
    obs_nxt = (code_nxt == '0) || (fcnt_n < half_n);
  end

  always_ff @(posedge clk) begin
    if (rst) fcnt <= '0;
    else     fcnt <= fcnt_n;
  end
endmodule

// File: rtl/slowdiv_half_stage.sv
module slowdiv_half_stage (
  input  logic clk,
  input  logic rst,
  input  logic in_wrap,
  input  logic halve,
  output logic out_wrap
);
  logic phase;

  // When halving, pass every second input wrap; otherwise pass each one.
  always_comb out_wrap = in_wrap && (!halve || phase);

  always_ff @(posedge clk) begin
    if (rst)          phase <= 1'b0;
    else if (in_wrap) phase <= halve ? ~phase : 1'b0;
  end
endmodule

// File: rtl/slow_clk_ratio_div.sv
module slow_clk_ratio_div
  import slowdiv_pkg::*;
#(
  parameter int CODE_W = SD_CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] slow_code,
  input  logic              hclk_half,
  input  logic              pclk_half,
  output logic              fclk_en,
  output logic              hclk_en,
  output logic              pclk_en,
  output logic              div_clk_obs
);
  localparam int NSTAGE = 2;

  slowdiv_cfg_t cfg_in, cfg_act, cfg_nxt;
  logic [CODE_W-1:0] act_code;
  logic              act_h, act_p;
  logic [NSTAGE:0]   wrap;
  logic [NSTAGE-1:0] halve;
  logic              obs_nxt;

  always_comb begin
    cfg_in.code   = slow_code;
    cfg_in.h_half = hclk_half;
    cfg_in.p_half = pclk_half;
    act_code      = cfg_act.code;
    act_h         = cfg_act.h_half;
    act_p         = cfg_act.p_half;
    halve         = {act_p, act_h};
  end

  slowdiv_cfg_hold u_cfg (
    .clk(clk), .rst(rst), .boundary(wrap[NSTAGE]),
    .cfg_in(cfg_in), .cfg_act(cfg_act), .cfg_nxt(cfg_nxt)
  );

  slowdiv_base_counter #(.CODE_W(CODE_W)) u_base (
    .clk(clk), .rst(rst), .code_act(cfg_act.code), .code_nxt(cfg_nxt.code),
    .f_wrap(wrap[0]), .obs_nxt(obs_nxt)
  );

  // Cascade of halving stages: F -> H -> P.
  for (genvar g = 0; g < NSTAGE; g++) begin : g_half
    slowdiv_half_stage u_stage (
      .clk(clk), .rst(rst), .in_wrap(wrap[g]), .halve(halve[g]),
      .out_wrap(wrap[g+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fclk_en     <= 1'b0;
      hclk_en     <= 1'b0;
      pclk_en     <= 1'b0;
      div_clk_obs <= 1'b0;
    end else begin
      fclk_en     <= wrap[0];
      hclk_en     <= wrap[1];
      pclk_en     <= wrap[2];
      div_clk_obs <= obs_nxt;
    end
  end
endmodule

// File: rtl/slowdiv_checker.sv
module slowdiv_checker #(
  parameter int CODE_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              fclk_en,
  input logic              hclk_en,
  input logic              pclk_en,
  input logic [CODE_W-1:0] act_code,
  input logic              act_h,
  input logic              act_p
);
  int unsigned gap;
  logic        seen;

  function automatic int unsigned ratio_of(input logic [CODE_W-1:0] c);
    return (c == '0) ? 1 : 2 * int'(c);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= 1;
      seen <= 1'b0;
    end else if (fclk_en) begin
      gap  <= 1;
      seen <= 1'b1;
    end else begin
      gap  <= gap + 1;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!fclk_en && !hclk_en && !pclk_en));

  assert_div1_every_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    (fclk_en && act_code == '0) |=> fclk_en);

  assert_f_spacing_R3: assert property (@(posedge clk) disable iff (rst)
    (fclk_en && seen) |-> (gap == ratio_of($past(act_code))));

  assert_h_on_f_grid_R6: assert property (@(posedge clk) disable iff (rst)
    hclk_en |-> fclk_en);

  assert_p_on_h_grid_R6: assert property (@(posedge clk) disable iff (rst)
    pclk_en |-> hclk_en);

  assert_cfg_only_at_boundary_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable({act_code, act_h, act_p}) |-> pclk_en);
endmodule

bind slow_clk_ratio_div slowdiv_checker #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .fclk_en(fclk_en), .hclk_en(hclk_en), .pclk_en(pclk_en),
  .act_code(act_code), .act_h(act_h), .act_p(act_p)
);

// File: tb/tb_slow_clk_ratio_div.sv
module tb_slow_clk_ratio_div;
  localparam int CLK_PERIOD = 10;
  localparam int CODE_W = 3;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CODE_W-1:0] slow_code = '0;
  logic hclk_half = 1'b0, pclk_half = 1'b0;
  logic fclk_en, hclk_en, pclk_en, div_clk_obs;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 1'b0;

  slow_clk_ratio_div #(.CODE_W(CODE_W)) dut (
    .clk(clk), .rst(rst), .slow_code(slow_code), .hclk_half(hclk_half),
    .pclk_half(pclk_half), .fclk_en(fclk_en), .hclk_en(hclk_en),
    .pclk_en(pclk_en), .div_clk_obs(div_clk_obs)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG && !done) begin
      failures = failures + 1;
      $display("FAIL watchdog: cycles %0d expected below %0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Advance to the next cycle that carries a pclk_en pulse.
  task automatic sync_p();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!pclk_en && n < 500);
    if (!pclk_en) check(1'b0, "R7", "no pclk_en pulse seen", 0, 1);
  endtask

  function automatic int ratio_of(input int c);
    return (c == 0) ? 1 : 2 * c;
  endfunction

  // Apply a setting, then compare two full P periods cycle by cycle.
  task automatic run_cfg(input int c, input bit h, input bit p);
    int f, hp, pp, bad_f, bad_h, bad_p, bad_o;
    bit ef, eh, ep, eo;
    f  = ratio_of(c);
    hp = f * (h ? 2 : 1);
    pp = hp * (p ? 2 : 1);
    slow_code = CODE_W'(c);
    hclk_half = h;
    pclk_half = p;
    sync_p();
    bad_f = 0; bad_h = 0; bad_p = 0; bad_o = 0;
    for (int k = 0; k < 2 * pp; k++) begin
      if (k > 0) @(negedge clk);
      ef = (k % f) == 0;
      eh = (k % hp) == 0;
      ep = (k % pp) == 0;
      eo = (f == 1) || ((k % f) < f / 2);
      if (fclk_en != ef) bad_f++;
      if (hclk_en != eh) bad_h++;
      if (pclk_en != ep) bad_p++;
      if (div_clk_obs != eo) bad_o++;
    end
    // R2 covers code 0, R3 covers the nonzero codes.
    check(bad_f == 0, (c == 0) ? "R2" : "R3", $sformatf("fclk_en cycle mismatches code=%0d h=%0d p=%0d", c, h, p), bad_f, 0);
    check(bad_h == 0, "R4", $sformatf("hclk_en cycle mismatches code=%0d h=%0d p=%0d", c, h, p), bad_h, 0);
    check(bad_p == 0, "R5", $sformatf("pclk_en cycle mismatches code=%0d h=%0d p=%0d", c, h, p), bad_p, 0);
    check(bad_o == 0, "R8", $sformatf("div_clk_obs cycle mismatches code=%0d h=%0d p=%0d", c, h, p), bad_o, 0);
  endtask

  initial begin
    int bad, bad_align;
    bit ef, ep;
    slow_code = '0;
    // R1: outputs stay quiet under reset.
    bad = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (i > 0 && (fclk_en || hclk_en || pclk_en || div_clk_obs)) bad++;
    end
    check(bad == 0, "R1", "active outputs during reset", bad, 0);
    rst = 1'b0;

    // R2-R5, R8: full sweep of codes and halving selects.
    for (int c = 0; c < (1 << CODE_W); c++)
      for (int o = 0; o < 4; o++)
        run_cfg(c, o[0], o[1]);

    // R7: mid-period change from the longest setting to divide-by-1.
    run_cfg(7, 1'b1, 1'b1);
    sync_p();
    bad = 0;
    bad_align = 0;
    for (int k = 1; k <= 60; k++) begin
      @(negedge clk);
      ef = (k <= 56) ? ((k % 14) == 0) : 1'b1;
      ep = (k <= 56) ? (k == 56) : 1'b1;
      if (fclk_en != ef || pclk_en != ep) bad++;
      if ((hclk_en && !fclk_en) || (pclk_en && !hclk_en)) bad_align++;
      if (k == 20) begin
        slow_code = '0;
        hclk_half = 1'b0;
        pclk_half = 1'b0;
      end
    end
    check(bad == 0, "R7", "pulse mismatches around mid-period change", bad, 0);
    check(bad_align == 0, "R6", "enable pulses off the F grid", bad_align, 0);

    // R1: reasserting reset silences outputs.
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(!(fclk_en || hclk_en || pclk_en || div_clk_obs), "R1",
          "outputs after reset reassertion", int'(fclk_en) + int'(pclk_en), 0);
    rst = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule